// File: doc/BRIEF.md
# Zero-Overhead Repeat Loop Controller

This block lets a DSP-style pipeline repeat a block of instructions with no branch at the bottom of the loop. Software loads a loop-start register, a loop-end register and a 12-bit repetition count. The controller watches every retiring instruction. Each instruction arrives with its address plus 4, because the fetch program counter runs ahead of the instruction being retired. When the final loop instruction completes and more repetitions remain, the controller tells fetch to resume at the top of the loop, in the same cycle.

The end of the loop is found early. The end register points at a detection instruction that sits three instructions before the final one. After that instruction retires, the controller counts three further retirements, and the third of these is the final instruction. Loops of one, two or three instructions have no room for that look-ahead. For these, the detection instruction is the one just before the loop, and the start register holds an offset code instead of an address. When the count is written, a 2-bit loop-size field is derived from the two registers. Short loops then repeat without running the detection instruction again.

Instructions are `INSTR_BYTES` (default 2) bytes long. The retire address input carries the instruction address plus `PC_AHEAD` (default 4).

Top module: `zloop_ctrl`

## Requirements
- R1: After reset, the repeat count is 0, the size flags are 00 and redirectValid is low.
- R2: A count write loads countWrData at the next clock edge. On the same edge, the size flags take a value from span = endReg - startReg (modulo 2^ADDR_W): span = -INSTR_BYTES gives 01 (one instruction), -2*INSTR_BYTES gives 10 (two), -3*INSTR_BYTES gives 11 (three), and any other value gives 00 (four or more instructions).
- R3: The size flags change only on a count write. Writes to the start or end register leave the flags and the count unchanged.
- R4: A retire that is not a taken branch, whose retirePc equals the end register, while the count is non-zero, arms the loop. The final instruction is then the 3rd following non-branch retire when the flags are 00, or the Nth following retire for a short loop of N instructions.
- R5: When the final instruction retires with count >= 2, redirectValid is high in that same cycle and the count is one lower after the next edge. The target is the start register when the flags are 00, and endReg - PC_AHEAD + INSTR_BYTES otherwise.
- R6: When the final instruction retires with count = 1, redirectValid stays low and the count becomes 0.
- R7: With the count at 0, the controller never redirects.
- R8: A taken branch that retires on the detection instruction, or on any retire while the loop is armed, cancels that pass. No redirect is issued for it and the count is unchanged.
- R9: A count write in the same cycle as a decrement wins, and the count takes the written value.
- R10: Starting from count C >= 1, a loop of any size issues exactly C-1 redirects, all to the loop's first instruction, and then falls through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startWrEn | input | 1 | Load the start register from wrAddr |
| endWrEn | input | 1 | Load the end register from wrAddr |
| countWrEn | input | 1 | Load the count from countWrData and derive the size flags |
| wrAddr | input | ADDR_W | Write data for the start and end registers |
| countWrData | input | CNT_W | Repetition count to load |
| retireValid | input | 1 | An instruction retires this cycle |
| retirePc | input | ADDR_W | Address of the retiring instruction plus PC_AHEAD |
| retireBranch | input | 1 | The retiring instruction is a taken branch |
| redirectValid | output | 1 | Fetch must resume at redirectTarget |
| redirectTarget | output | ADDR_W | Address of the first loop instruction |
| repeatCount | output | CNT_W | Remaining repetitions |
| repeatFlags | output | 2 | Loop-size flags |

## Verification
The bench sweeps loops of one, two, three, four and eight instructions with counts of 1, 2 and 4095. It predicts every redirect cycle and target from the loop geometry. A design that counted the look-ahead wrongly would redirect one instruction early or late. A design that re-armed short loops wrongly would issue only one redirect, or would never stop. Count-of-one and count-of-zero runs catch an extra redirect at the last pass, or a loop that starts from a zero count. Directed runs check that a taken branch on the detection instruction, or later in the same pass, suppresses the redirect. They also check that a count write beats a same-cycle decrement, and that later start or end writes do not disturb the latched flags.

// File: rtl/zloop_pkg.sv
package zloop_pkg;
  localparam int LOOKAHEAD = 3;   // instructions from detection to final
  localparam int MAX_SHORT = 3;   // longest loop encoded by the flags

  typedef enum logic [1:0] {
    SZ_LONG  = 2'b00,
    SZ_ONE   = 2'b01,
    SZ_TWO   = 2'b10,
    SZ_THREE = 2'b11
  } loopSize_e;

  typedef struct packed {
    logic decCount;
    logic clearCount;
    logic redirect;
  } loopCtrl_t;
endpackage

// File: rtl/zloop_datapath.sv
module zloop_datapath
  import zloop_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 12,
  parameter int INSTR_BYTES = 2,
  parameter int PC_AHEAD    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWrEn,
  input  logic              endWrEn,
  input  logic              countWrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  countWrData,
  input  logic [ADDR_W-1:0] retirePc,
  input  loopCtrl_t         ctrl,
  output logic              endMatch,
  output logic              countNonZero,
  output logic              countGeTwo,
  output loopSize_e         sizeFlags,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] target
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(PC_AHEAD);

  logic [ADDR_W-1:0] startReg;
  logic [ADDR_W-1:0] endReg;
  logic [ADDR_W-1:0] span;
  loopSize_e         derived;

  assign span = endReg - startReg;

  // Short loops store start = end + N*step, so span is -N*step.
  always_comb begin
    derived = SZ_LONG;
    for (int k = 1; k <= MAX_SHORT; k++) begin
      if (span == ADDR_W'(0) - ADDR_W'(k * INSTR_BYTES)) derived = loopSize_e'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg  <= '0;
      endReg    <= '0;
      count     <= '0;
      sizeFlags <= SZ_LONG;
    end else begin
      if (startWrEn) startReg <= wrAddr;
      if (endWrEn)   endReg   <= wrAddr;
      if (countWrEn) begin
        count     <= countWrData;
        sizeFlags <= derived;
      end else if (ctrl.decCount) begin
        count <= count - CNT_W'(1);
      end else if (ctrl.clearCount) begin
        count <= '0;
      end
    end
  end

  assign endMatch     = (retirePc == endReg);
  assign countNonZero = (count != '0);
  assign countGeTwo   = (count >= CNT_W'(2));
  assign target       = (sizeFlags == SZ_LONG) ? startReg : (endReg - AHEAD + STEP);
endmodule

// File: rtl/zloop_control.sv
module zloop_control
  import zloop_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      countWrEn,
  input  logic      retireValid,
  input  logic      retireBranch,
  input  logic      endMatch,
  input  logic      countNonZero,
  input  logic      countGeTwo,
  input  loopSize_e sizeFlags,
  output loopCtrl_t ctrl
);
  logic       armed;
  logic [1:0] stepsLeft;
  logic [1:0] stepsLoad;
  logic       goodRetire;
  logic       finalStep;

  assign stepsLoad  = (sizeFlags == SZ_LONG) ? 2'(LOOKAHEAD) : 2'(sizeFlags);
  assign goodRetire = retireValid && !retireBranch;
  assign finalStep  = armed && goodRetire && (stepsLeft == 2'd1);

  always_comb begin
    ctrl.redirect   = finalStep && countGeTwo;
    ctrl.decCount   = finalStep && countGeTwo;
    ctrl.clearCount = finalStep && !countGeTwo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      stepsLeft <= 2'd0;
    end else if (countWrEn) begin
      armed <= 1'b0;
    end else if (retireValid && retireBranch) begin
      armed <= 1'b0;
    end else if (goodRetire) begin
      if (armed) begin
        if (stepsLeft == 2'd1) begin
          // Short loops never re-run their detection instruction: re-arm here.
          if (countGeTwo && sizeFlags != SZ_LONG) stepsLeft <= stepsLoad;
          else armed <= 1'b0;
        end else begin
          stepsLeft <= stepsLeft - 2'd1;
        end
      end else if (endMatch && countNonZero) begin
        armed     <= 1'b1;
        stepsLeft <= stepsLoad;
      end
    end
  end
endmodule

// File: rtl/zloop_ctrl.sv
module zloop_ctrl
  import zloop_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 12,
  parameter int INSTR_BYTES = 2,
  parameter int PC_AHEAD    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWrEn,
  input  logic              endWrEn,
  input  logic              countWrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  countWrData,
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] retirePc,
  input  logic              retireBranch,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectTarget,
  output logic [CNT_W-1:0]  repeatCount,
  output logic [1:0]        repeatFlags
);
  loopCtrl_t ctrl;
  loopSize_e sizeFlags;
  logic      endMatch;
  logic      countNonZero;
  logic      countGeTwo;

  zloop_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .INSTR_BYTES(INSTR_BYTES), .PC_AHEAD(PC_AHEAD)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .startWrEn(startWrEn), .endWrEn(endWrEn), .countWrEn(countWrEn),
    .wrAddr(wrAddr), .countWrData(countWrData), .retirePc(retirePc),
    .ctrl(ctrl), .endMatch(endMatch), .countNonZero(countNonZero),
    .countGeTwo(countGeTwo), .sizeFlags(sizeFlags), .count(repeatCount),
    .target(redirectTarget)
  );

  zloop_control u_control (
    .clk(clk), .rstN(rstN), .countWrEn(countWrEn),
    .retireValid(retireValid), .retireBranch(retireBranch),
    .endMatch(endMatch), .countNonZero(countNonZero), .countGeTwo(countGeTwo),
    .sizeFlags(sizeFlags), .ctrl(ctrl)
  );

  assign redirectValid = ctrl.redirect;
  assign repeatFlags   = sizeFlags;
endmodule

// File: rtl/zloop_checker.sv
module zloop_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             countWrEn,
  input logic [CNT_W-1:0] countWrData,
  input logic             retireValid,
  input logic             retireBranch,
  input logic             redirectValid,
  input logic [CNT_W-1:0] repeatCount,
  input logic [1:0]       repeatFlags
);
  p_load_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    countWrEn |=> repeatCount == $past(countWrData));

  p_flags_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !countWrEn |=> $stable(repeatFlags));

  p_redirect_on_retire_r4: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> retireValid);

  p_redirect_needs_two_r5: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> repeatCount >= CNT_W'(2));

  p_decrement_after_redirect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && !countWrEn) |=> repeatCount == $past(repeatCount) - CNT_W'(1));

  p_count_never_grows_r6: assert property (@(posedge clk) disable iff (!rstN)
    !countWrEn |=> repeatCount <= $past(repeatCount));

  p_zero_count_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (repeatCount == '0) |-> !redirectValid);

  p_branch_blocks_redirect_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retireValid && retireBranch) |-> !redirectValid);
endmodule

bind zloop_ctrl zloop_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rstN(rstN), .countWrEn(countWrEn), .countWrData(countWrData),
  .retireValid(retireValid), .retireBranch(retireBranch),
  .redirectValid(redirectValid), .repeatCount(repeatCount), .repeatFlags(repeatFlags)
);

// File: tb/zloop_ctrl_bench.sv
module zloop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IB = 2;
  localparam int AH = 4;
  localparam logic [31:0] BASE = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startWrEn = 1'b0, endWrEn = 1'b0, countWrEn = 1'b0;
  logic [31:0] wrAddr = '0;
  logic [11:0] countWrData = '0;
  logic        retireValid = 1'b0, retireBranch = 1'b0;
  logic [31:0] retirePc = '0;
  logic        redirectValid;
  logic [31:0] redirectTarget;
  logic [11:0] repeatCount;
  logic [1:0]  repeatFlags;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  zloop_ctrl u_zloop_ctrl (
    .clk(clk), .rstN(rstN), .startWrEn(startWrEn), .endWrEn(endWrEn),
    .countWrEn(countWrEn), .wrAddr(wrAddr), .countWrData(countWrData),
    .retireValid(retireValid), .retirePc(retirePc), .retireBranch(retireBranch),
    .redirectValid(redirectValid), .redirectTarget(redirectTarget),
    .repeatCount(repeatCount), .repeatFlags(repeatFlags)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic rv, input logic [31:0] pcIn, input logic br,
                     input logic sw, input logic ew, input logic cw,
                     input logic [31:0] addr, input logic [11:0] cdata,
                     output logic rd, output logic [31:0] tg);
    @(negedge clk);
    retireValid = rv; retirePc = pcIn; retireBranch = br;
    startWrEn = sw; endWrEn = ew; countWrEn = cw; wrAddr = addr; countWrData = cdata;
    #1;
    rd = redirectValid; tg = redirectTarget;
  endtask

  task automatic idle();
    logic rd; logic [31:0] tg;
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, rd, tg);
  endtask

  task automatic setLoop(input logic [31:0] s, input logic [31:0] e, input int cnt);
    logic rd; logic [31:0] tg;
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, s, '0, rd, tg);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, e, '0, rd, tg);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, '0, 12'(cnt), rd, tg);
    idle();
  endtask

  // Retire one instruction at address a; returns redirect seen.
  task automatic retire(input logic [31:0] a, input logic br, output logic rd,
                        output logic [31:0] tg);
    cyc(1'b1, a + AH, br, 1'b0, 1'b0, 1'b0, '0, '0, rd, tg);
  endtask

  function automatic logic [31:0] endFor(input int n);
    return (n >= 4) ? BASE + 32'((n - 4) * IB + AH) : BASE - IB + AH;
  endfunction

  function automatic logic [31:0] startFor(input int n);
    return (n >= 4) ? BASE : endFor(n) + 32'(n * IB);
  endfunction

  task automatic runLoop(input int n, input int cnt);
    logic [31:0] pc, fin, tg;
    logic rd, expRd;
    int k, got, bad, badTgt;
    setLoop(startFor(n), endFor(n), cnt);
    check(repeatCount == 12'(cnt), "R2", $sformatf("count load n=%0d", n), repeatCount, cnt);
    check(repeatFlags == ((n <= 3) ? 2'(n) : 2'd0), "R2", $sformatf("flags n=%0d", n),
          repeatFlags, (n <= 3) ? n : 0);
    pc = BASE - 2 * IB; fin = BASE + 32'((n - 1) * IB); k = cnt;
    got = 0; bad = 0; badTgt = 0;
    while (pc != BASE + 32'((n + 2) * IB)) begin
      retire(pc, 1'b0, rd, tg);
      expRd = (pc == fin) && (k >= 2);
      if (rd != expRd) bad++;
      if (rd) begin got++; if (tg != BASE) badTgt++; end
      if (pc == fin && k >= 2) begin k--; pc = BASE; end
      else pc = pc + IB;
    end
    idle();
    check(bad == 0, "R4", $sformatf("redirect timing mismatches n=%0d c=%0d", n, cnt), bad, 0);
    check(got == cnt - 1, "R10", $sformatf("redirect total n=%0d c=%0d", n, cnt), got, cnt - 1);
    check(badTgt == 0, "R5", $sformatf("wrong targets n=%0d c=%0d", n, cnt), badTgt, 0);
    check(repeatCount == 0, "R6", $sformatf("final count n=%0d c=%0d", n, cnt), repeatCount, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic rd; logic [31:0] tg;
    int seen;
    int sizes[5] = '{1, 2, 3, 4, 8};
    int counts[3] = '{1, 2, 4095};
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check(repeatCount == 0, "R1", "reset count", repeatCount, 0);
    check(repeatFlags == 0, "R1", "reset flags", repeatFlags, 0);
    check(redirectValid == 0, "R1", "reset redirect", redirectValid, 0);

    foreach (sizes[i]) foreach (counts[j]) runLoop(sizes[i], counts[j]);

    // R3: start/end writes after a count write leave flags and count alone
    runLoop(3, 2);
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, BASE, '0, rd, tg);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, BASE + 100, '0, rd, tg);
    idle();
    check(repeatFlags == 2'd3, "R3", "flags after start/end writes", repeatFlags, 3);
    check(repeatCount == 0, "R3", "count after start/end writes", repeatCount, 0);

    // R7: zero count, eight-instruction loop never redirects
    setLoop(startFor(8), endFor(8), 0);
    seen = 0;
    for (int p = 0; p < 12; p++) begin
      retire(BASE + 32'(p * IB), 1'b0, rd, tg);
      if (rd) seen++;
    end
    check(seen == 0, "R7", "redirects with zero count", seen, 0);

    // R8: taken branch on the detection instruction (BASE+4*IB)
    setLoop(startFor(8), endFor(8), 3);
    seen = 0;
    for (int p = 0; p < 8; p++) begin
      retire(BASE + 32'(p * IB), (p == 4), rd, tg);
      if (rd) seen++;
    end
    idle();
    check(seen == 0, "R8", "redirects with branch on detection", seen, 0);
    check(repeatCount == 3, "R8", "count after cancelled pass", repeatCount, 3);
    // clean pass: one redirect at the final instruction to BASE
    seen = 0;
    for (int p = 0; p < 8; p++) begin
      retire(BASE + 32'(p * IB), 1'b0, rd, tg);
      if (rd) begin
        seen++;
        check(p == 7 && tg == BASE, "R5", "redirect slot/target", tg, BASE);
      end
    end
    idle();
    check(seen == 1, "R5", "one redirect on clean pass", seen, 1);
    check(repeatCount == 2, "R5", "count after redirect", repeatCount, 2);
    // branch retiring while armed (after detection)
    seen = 0;
    for (int p = 0; p < 8; p++) begin
      retire(BASE + 32'(p * IB), (p == 5), rd, tg);
      if (rd) seen++;
    end
    idle();
    check(seen == 0, "R8", "redirects with branch while armed", seen, 0);
    check(repeatCount == 2, "R8", "count after armed cancel", repeatCount, 2);

    // R9: count write in the cycle of a decrement, four-instruction loop
    setLoop(startFor(4), endFor(4), 5);
    for (int p = 0; p < 3; p++) retire(BASE + 32'(p * IB), 1'b0, rd, tg);
    cyc(1'b1, BASE + 3 * IB + AH, 1'b0, 1'b0, 1'b0, 1'b1, '0, 12'd77, rd, tg);
    check(rd == 1'b1, "R5", "redirect in write cycle", rd, 1);
    idle();
    check(repeatCount == 77, "R9", "write beats decrement", repeatCount, 77);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule